// File: doc/BRIEF.md
# Vector Register Load Aligner

The block fills a 128-bit vector register, held as eight 16-bit lanes, from a 4 KB byte-addressed data memory that stores bytes big-endian. A load may begin at any byte address. The block fetches the two 8-byte memory words that cover the access and rotates the resulting 16 bytes so that the first requested byte lands at a chosen register byte position, called the element. It then merges the rotated bytes into the previous register value under a byte mask that it builds from the access kind, the size and the element.

Three load kinds are supported. A short load moves 1, 2, 4 or 8 bytes, and any bytes that would run past the last register byte are dropped. A quad load moves bytes from the address up to the end of its 16-byte quadword. A rest load fills the register tail with the opposite byte set of a quad load. The memory model inside the block has a one-cycle synchronous read and a byte write port that is used to preload it. A request is sampled on `start_i`, and the merged register appears with a one-cycle `done_o` pulse.

Top module: `vec_load_aligner`

## Requirements
- R1: While reset is held and after it is released, `done_o` is 0 and `vec_o` is all zeros until the first result.
- R2: A request sampled with `start_i` on clock edge k gives `done_o` high for exactly the cycle after edge k+1. Requests may be issued on consecutive cycles. `vec_o` holds its value in every cycle where `done_o` is low.
- R3: Register byte position p (0..15) sits in lane p/2. An even p is the lane's high byte, `vec_o[16*(p/2)+15 -: 8]`, and an odd p is its low byte, `vec_o[16*(p/2)+7 -: 8]`. The first byte a load moves lands at position `elem_i`.
- R4: Short load (`mode_i`=0). N = 1 << `size_i` (size codes 0..3 give 1, 2, 4 or 8 bytes). Register position elem+k, for k < N, takes the memory byte at addr+k. This holds when the access crosses an 8-byte word boundary.
- R5: In a short load, bytes whose position elem+k would exceed 15 are dropped. They do not wrap to the start of the register.
- R6: Memory addresses wrap modulo 4096. A short load near 0xFFF continues from address 0.
- R7: Quad load (`mode_i`=1). With off = addr & 15, position elem+k takes the byte at addr+k for k < 16-off and elem+k <= 15. No byte past the end of the quadword is read.
- R8: Rest load (`mode_i`=2). With off = addr & 15, positions 16-off..15 take the byte at (addr & 0xFF0) + ((p - off) mod 16). The element is ignored. When off = 0, nothing is written.
- R9: `mode_i`=3 writes no byte. The result equals the old register value, and `done_o` still pulses.
- R10: Every register byte position that a load does not write returns the byte of `old_vec_i` sampled with the request.
- R11: A byte written through the write port is returned by a load sampled on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_we_i | input | 1 | Memory byte write enable |
| mem_waddr_i | input | 12 | Memory byte write address |
| mem_wdata_i | input | 8 | Memory byte write data |
| start_i | input | 1 | Load request strobe |
| mode_i | input | 2 | Load kind: 0 short, 1 quad, 2 rest, 3 none |
| size_i | input | 2 | Short load size code, N = 1 << size_i bytes |
| addr_i | input | 12 | Load start byte address |
| elem_i | input | 4 | First register byte position |
| old_vec_i | input | 128 | Previous register value |
| done_o | output | 1 | Result valid pulse |
| vec_o | output | 128 | Merged register value |

## Verification
A wrong bank-swap or row selection shows as whole 8-byte groups taken from the wrong word. This is visible on `vec_o` at the `done_o` pulse that follows that request's read. A stale or wrongly built byte mask shows either as old register bytes surviving where fresh data was due, or as fresh bytes overwriting bytes that should have been kept. A wrong rotate amount moves every loaded byte to a neighbouring position. Each of these faults appears in the first result after the faulty request, one edge after the memory read, so random addresses and elements combined with directed word-crossing, wrap and boundary cases expose them at once.

// File: rtl/vla_pkg.sv
package vla_pkg;
  typedef enum logic [1:0] {
    LD_SHORT = 2'd0,
    LD_QUAD  = 2'd1,
    LD_REST  = 2'd2,
    LD_NONE  = 2'd3
  } ld_mode_e;
endpackage

// File: rtl/vla_mem.sv
module vla_mem #(
  parameter int ADDR_W     = 12,
  parameter int WORD_BYTES = 8
) (
  input  logic                              clk_i,
  input  logic                              we_i,
  input  logic [ADDR_W-1:0]                 waddr_i,
  input  logic [7:0]                        wdata_i,
  input  logic [ADDR_W-$clog2(WORD_BYTES)-1:0] rd_word_i,
  output logic [WORD_BYTES-1:0][7:0]        lo_o,
  output logic [WORD_BYTES-1:0][7:0]        hi_o
);
  localparam int WB_W  = $clog2(WORD_BYTES);
  localparam int WI_W  = ADDR_W - WB_W;
  localparam int ROW_W = WI_W - 1;
  localparam int ROWS  = 1 << ROW_W;

  logic [ROW_W-1:0] lo_row;
  logic             swap_q;

  assign lo_row = rd_word_i[WI_W-1:1];

  // even/odd word banks: any two consecutive words hit different banks
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_BYTES-1:0][7:0] mem_q [ROWS];
    logic [WORD_BYTES-1:0][7:0] rd_q;
    logic [ROW_W-1:0]           row_sel;

    assign row_sel = (rd_word_i[0] == 1'(b)) ? lo_row : lo_row + ROW_W'(rd_word_i[0]);

    always_ff @(posedge clk_i) begin
      if (we_i && waddr_i[WB_W] == 1'(b))
        mem_q[waddr_i[ADDR_W-1:WB_W+1]][waddr_i[WB_W-1:0]] <= wdata_i;
      rd_q <= mem_q[row_sel];
    end
  end

  always_ff @(posedge clk_i) swap_q <= rd_word_i[0];

  assign lo_o = swap_q ? g_bank[1].rd_q : g_bank[0].rd_q;
  assign hi_o = swap_q ? g_bank[0].rd_q : g_bank[1].rd_q;
endmodule

// File: rtl/vla_mask_gen.sv
module vla_mask_gen
  import vla_pkg::*;
#(
  parameter int VEC_BYTES = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [1:0]                   mode_i,
  input  logic [1:0]                   size_i,
  input  logic [$clog2(VEC_BYTES)-1:0] elem_i,
  input  logic [$clog2(VEC_BYTES)-1:0] off_i,
  output logic [VEC_BYTES-1:0]         mask_o,
  output logic [$clog2(VEC_BYTES)-1:0] ror_o
);
  localparam int EL_W = $clog2(VEC_BYTES);
  localparam int WB_W = EL_W - 1;

  logic [EL_W:0]      n_short, n_quad;
  logic [VEC_BYTES:0] run_short, run_quad;

  always_comb begin
    n_short   = (EL_W+1)'(1) << size_i;
    n_quad    = (EL_W+1)'(VEC_BYTES) - (EL_W+1)'(off_i);
    run_short = ((VEC_BYTES+1)'(1) << n_short) - (VEC_BYTES+1)'(1);
    run_quad  = ((VEC_BYTES+1)'(1) << n_quad) - (VEC_BYTES+1)'(1);
    mask_o    = '0;
    ror_o     = '0;
    case (ld_mode_e'(mode_i))
      LD_SHORT: begin
        mask_o = VEC_BYTES'(run_short << elem_i);
        ror_o  = {1'b0, off_i[WB_W-1:0]} - elem_i;
      end
      LD_QUAD: begin
        mask_o = VEC_BYTES'(run_quad << elem_i);
        ror_o  = off_i - elem_i;
      end
      LD_REST: begin
        mask_o = ~VEC_BYTES'(run_quad);
        ror_o  = EL_W'(0) - off_i;
      end
      default: ;
    endcase
  end

  a_r4_short_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == LD_SHORT |-> $countones(mask_o) <= (32'd1 << size_i));
  a_r3_first_at_elem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == LD_SHORT |-> mask_o[elem_i]);
  a_r8_rest_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == LD_REST |-> $countones(mask_o) == 32'(off_i));
  a_r9_none_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == LD_NONE |-> mask_o == '0);
endmodule

// File: rtl/vla_rotator.sv
module vla_rotator #(
  parameter int VEC_BYTES = 16
) (
  input  logic [VEC_BYTES-1:0][7:0]    src_i,
  input  logic [$clog2(VEC_BYTES)-1:0] ror_i,
  output logic [VEC_BYTES-1:0][7:0]    out_o
);
  localparam int EL_W = $clog2(VEC_BYTES);

  for (genvar p = 0; p < VEC_BYTES; p++) begin : g_pos
    assign out_o[p] = src_i[EL_W'(p) + ror_i];
  end
endmodule

// File: rtl/vec_load_aligner.sv
module vec_load_aligner
  import vla_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int LANES  = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              mem_we_i,
  input  logic [ADDR_W-1:0]                 mem_waddr_i,
  input  logic [7:0]                        mem_wdata_i,
  input  logic                              start_i,
  input  logic [1:0]                        mode_i,
  input  logic [1:0]                        size_i,
  input  logic [ADDR_W-1:0]                 addr_i,
  input  logic [$clog2(LANES*2)-1:0]        elem_i,
  input  logic [LANES*16-1:0]               old_vec_i,
  output logic                              done_o,
  output logic [LANES*16-1:0]               vec_o
);
  localparam int VEC_BYTES  = LANES * 2;
  localparam int VEC_W      = LANES * 16;
  localparam int EL_W       = $clog2(VEC_BYTES);
  localparam int WORD_BYTES = VEC_BYTES / 2;
  localparam int WB_W       = $clog2(WORD_BYTES);
  localparam int WI_W       = ADDR_W - WB_W;

  logic [WI_W-1:0]               rd_word;
  logic [VEC_BYTES-1:0]          mask_d;
  logic [EL_W-1:0]               ror_d;
  logic [WORD_BYTES-1:0][7:0]    lo_w, hi_w;
  logic [VEC_BYTES-1:0][7:0]     fetched, rotated;
  logic [VEC_W-1:0]              merged;

  logic                          s1_valid_q;
  logic [VEC_BYTES-1:0]          s1_mask_q;
  logic [EL_W-1:0]               s1_ror_q;
  logic [VEC_W-1:0]              s1_old_q;

  assign rd_word = (mode_i == LD_SHORT) ? addr_i[ADDR_W-1:WB_W]
                                        : {addr_i[ADDR_W-1:WB_W+1], 1'b0};

  vla_mem #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_mem (
    .clk_i     (clk_i),
    .we_i      (mem_we_i),
    .waddr_i   (mem_waddr_i),
    .wdata_i   (mem_wdata_i),
    .rd_word_i (rd_word),
    .lo_o      (lo_w),
    .hi_o      (hi_w)
  );

  vla_mask_gen #(.VEC_BYTES(VEC_BYTES)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .size_i (size_i),
    .elem_i (elem_i),
    .off_i  (addr_i[EL_W-1:0]),
    .mask_o (mask_d),
    .ror_o  (ror_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_mask_q  <= '0;
      s1_ror_q   <= '0;
      s1_old_q   <= '0;
    end else begin
      s1_valid_q <= start_i;
      if (start_i) begin
        s1_mask_q <= mask_d;
        s1_ror_q  <= ror_d;
        s1_old_q  <= old_vec_i;
      end
    end
  end

  assign fetched = {hi_w, lo_w};

  vla_rotator #(.VEC_BYTES(VEC_BYTES)) u_rot (
    .src_i (fetched),
    .ror_i (s1_ror_q),
    .out_o (rotated)
  );

  // big-endian lanes: even byte position is the lane's high byte
  for (genvar p = 0; p < VEC_BYTES; p++) begin : g_merge
    localparam int BIT = 16 * (p / 2) + ((p % 2 == 0) ? 8 : 0);
    assign merged[BIT +: 8] = s1_mask_q[p] ? rotated[p] : s1_old_q[BIT +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      vec_o  <= '0;
    end else begin
      done_o <= s1_valid_q;
      if (s1_valid_q) vec_o <= merged;
    end
  end

  a_r2_done_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> ##1 done_o);
  a_r2_done_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 2));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(vec_o));
endmodule

// File: tb/vec_load_aligner_bench.sv
`timescale 1ns/1ps
module vec_load_aligner_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         mem_we;
  logic [11:0]  mem_waddr;
  logic [7:0]   mem_wdata;
  logic         start;
  logic [1:0]   mode;
  logic [1:0]   size;
  logic [11:0]  addr;
  logic [3:0]   elem;
  logic [127:0] old_vec;
  logic         done;
  logic [127:0] vec;

  logic [7:0]   mem_m [4096];
  int           n_checks = 0;
  int           n_err    = 0;
  bit           finished = 1'b0;

  always #4 clk = ~clk;

  vec_load_aligner u_vec_load_aligner (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .mem_we_i    (mem_we),
    .mem_waddr_i (mem_waddr),
    .mem_wdata_i (mem_wdata),
    .start_i     (start),
    .mode_i      (mode),
    .size_i      (size),
    .addr_i      (addr),
    .elem_i      (elem),
    .old_vec_i   (old_vec),
    .done_o      (done),
    .vec_o       (vec)
  );

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [1:0] md, input logic [1:0] sz,
                                         input logic [11:0] a, input logic [3:0] e,
                                         input logic [127:0] old);
    logic [127:0] r;
    int off4, n, ei;
    r    = old;
    off4 = int'(a[3:0]);
    n    = 1 << sz;
    ei   = int'(e);
    for (int p = 0; p < 16; p++) begin
      bit w;
      int src;
      w   = 1'b0;
      src = 0;
      case (md)
        2'd0: begin w = (p >= ei) && (p - ei < n);         src = (int'(a) + p - ei) & 12'hFFF; end
        2'd1: begin w = (p >= ei) && (p - ei < 16 - off4); src = int'(a) + p - ei; end
        2'd2: begin w = (p >= 16 - off4);                  src = int'({a[11:4], 4'h0}) + ((p - off4) & 15); end
        default: w = 1'b0;
      endcase
      if (w) r[16*(p/2) + ((p % 2 == 0) ? 8 : 0) +: 8] = mem_m[src];
    end
    return r;
  endfunction

  task automatic write_byte(input logic [11:0] a, input logic [7:0] d);
    mem_we = 1'b1; mem_waddr = a; mem_wdata = d;
    mem_m[a] = d;
    @(negedge clk);
    mem_we = 1'b0;
  endtask

  task automatic drive(input logic [1:0] md, input logic [1:0] sz, input logic [11:0] a,
                       input logic [3:0] e, input logic [127:0] old);
    start = 1'b1; mode = md; size = sz; addr = a; elem = e; old_vec = old;
  endtask

  task automatic run_load(input logic [1:0] md, input logic [1:0] sz, input logic [11:0] a,
                          input logic [3:0] e, input logic [127:0] old, input string req);
    logic [127:0] exp, got;
    exp = model(md, sz, a, e, old);
    drive(md, sz, a, e, old);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R2 done early", 128'(done), 128'd0);
    @(negedge clk);
    check(done == 1'b1, "R2 done pulse", 128'(done), 128'd1);
    check(vec == exp, req, vec, exp);
    got = vec;
    @(negedge clk);
    check(done == 1'b0, "R2 single pulse", 128'(done), 128'd0);
    check(vec == got, "R2 hold", vec, got);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [127:0] o1, o2, e1, e2;
    void'($urandom(32'd2024));
    rst_n = 1'b0; mem_we = 1'b0; mem_waddr = '0; mem_wdata = '0;
    start = 1'b0; mode = '0; size = '0; addr = '0; elem = '0; old_vec = '0;
    repeat (4) @(negedge clk);
    check(done == 1'b0, "R1 reset done", 128'(done), 128'd0);
    check(vec == '0, "R1 reset vec", vec, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && vec == '0, "R1 after release", vec, 128'd0);

    for (int i = 0; i < 4096; i++) write_byte(12'(i), 8'($urandom));

    // R3: single byte to position 0 is lane 0 high byte; position 1 low byte
    run_load(2'd0, 2'd0, 12'h010, 4'd0, '0, "R3 byte to lane0 high");
    check(vec[15:8] == mem_m[12'h010] && vec[7:0] == 8'h00, "R3 lane0 high byte", vec, 128'(mem_m[12'h010]) << 8);
    run_load(2'd0, 2'd0, 12'h011, 4'd1, '0, "R3 byte to lane0 low");
    check(vec[7:0] == mem_m[12'h011], "R3 lane0 low byte", 128'(vec[7:0]), 128'(mem_m[12'h011]));
    // R4 aligned and word-crossing
    run_load(2'd0, 2'd3, 12'h020, 4'd0, rnd128(), "R4 short aligned 8");
    run_load(2'd0, 2'd3, 12'h02D, 4'd2, rnd128(), "R4 short crossing words");
    run_load(2'd0, 2'd1, 12'h047, 4'd7, rnd128(), "R4 short 2 across word");
    run_load(2'd0, 2'd2, 12'h0FE, 4'd4, rnd128(), "R4 short 4 misaligned");
    // R5 drop past end
    run_load(2'd0, 2'd3, 12'h033, 4'd12, rnd128(), "R5 short past last byte");
    run_load(2'd0, 2'd2, 12'h050, 4'd15, rnd128(), "R5 short at last byte");
    // R6 wrap at 4KB
    run_load(2'd0, 2'd3, 12'hFFC, 4'd0, rnd128(), "R6 wrap to address 0");
    run_load(2'd0, 2'd3, 12'hFF9, 4'd3, rnd128(), "R6 wrap misaligned");
    // R7 quad
    run_load(2'd1, 2'd0, 12'h120, 4'd0, rnd128(), "R7 quad aligned");
    run_load(2'd1, 2'd0, 12'h125, 4'd0, rnd128(), "R7 quad offset 5");
    run_load(2'd1, 2'd0, 12'h12A, 4'd5, rnd128(), "R7 quad with element");
    run_load(2'd1, 2'd0, 12'hFFF, 4'd9, rnd128(), "R7 quad last byte");
    // R8 rest
    run_load(2'd2, 2'd0, 12'h137, 4'd0, rnd128(), "R8 rest offset 7");
    run_load(2'd2, 2'd0, 12'h13F, 4'd6, rnd128(), "R8 rest element ignored");
    o1 = rnd128();
    run_load(2'd2, 2'd0, 12'h140, 4'd0, o1, "R8 rest offset 0 writes nothing");
    check(vec == o1, "R8 rest offset 0 keeps old", vec, o1);
    // R9 none
    o1 = rnd128();
    run_load(2'd3, 2'd3, 12'h155, 4'd3, o1, "R9 no-write mode");
    check(vec == o1, "R9 keeps old value", vec, o1);
    // R10 keep old bytes
    o1 = rnd128();
    run_load(2'd0, 2'd0, 12'h160, 4'd8, o1, "R10 single byte keeps rest");
    check(vec[127:80] == o1[127:80] && vec[63:0] == o1[63:0], "R10 untouched lanes", vec, o1);
    // R11 write then load next edge
    write_byte(12'h200, 8'hA5);
    run_load(2'd0, 2'd0, 12'h200, 4'd0, '0, "R11 fresh write visible");
    check(vec[15:8] == 8'hA5, "R11 fresh byte", 128'(vec[15:8]), 128'hA5);

    // R2 back-to-back requests
    o1 = rnd128(); o2 = rnd128();
    e1 = model(2'd0, 2'd3, 12'h305, 4'd1, o1);
    e2 = model(2'd1, 2'd0, 12'h3A3, 4'd2, o2);
    drive(2'd0, 2'd3, 12'h305, 4'd1, o1);
    @(negedge clk);
    drive(2'd1, 2'd0, 12'h3A3, 4'd2, o2);
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b1 && vec == e1, "R2 back-to-back first", vec, e1);
    @(negedge clk);
    check(done == 1'b1 && vec == e2, "R2 back-to-back second", vec, e2);
    @(negedge clk);
    check(done == 1'b0, "R2 back-to-back end", 128'(done), 128'd0);

    for (int i = 0; i < 500; i++) begin
      logic [1:0] md;
      md = 2'($urandom_range(0, 3));
      run_load(md, 2'($urandom), 12'($urandom), 4'($urandom), rnd128(),
               md == 2'd0 ? "R4 random short" : md == 2'd1 ? "R7 random quad" :
               md == 2'd2 ? "R8 random rest" : "R9 random none");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule